// File: doc/BRIEF.md
# Disciplined Seconds-and-Fraction Packet Timestamper

This block keeps a 64-bit time of day next to a receive MAC and stamps every incoming frame with it. The upper half of the time value counts whole seconds. The lower half is a binary fraction of one second, so one unit is 2^-32 s. On every clock the fraction moves forward by a 32.32 fixed-point increment held in a phase accumulator. Because the increment is set from outside, a slow or fast oscillator can be trimmed: at 160 MHz the nominal value is about 26.84 units per cycle.

A pulse-per-second input, for example from a GPS receiver, passes through a two-flop synchronizer and an edge detector. Each recognized rising edge does two things. It snaps the fraction to zero, and it records how many clocks have passed since the previous edge, so that software can correct the increment. When the pulse has been missing for one and a half nominal seconds, a loss flag is raised and the counter keeps running on its increment alone.

Received frames arrive as a stream of beats with valid and last. Each frame is forwarded one cycle later. The time at its first beat is then appended as one extra beat that closes the frame.

Top module: `gps_stamper`

## Requirements
- R1: While rst_n is low, and until the first clock edge after it goes high, time_o is 0 and pps_lost_o, pps_period_valid_o and tx_valid_o are all 0.
- R2: When the fraction (time_o[31:0]) wraps past 2^32, the seconds field (time_o[63:32]) increases by exactly one on that same clock edge.
- R3: When no realignment happens, each clock adds incr_i to the 96-bit register {seconds, fraction, sub-fraction}. incr_i[63:32] is added to the fraction and incr_i[31:0] to a hidden 32-bit sub-fraction. The carry out of the sub-fraction adds one more unit to the fraction. Two steps of incr_i = {26, 0x80000000} therefore advance the fraction by exactly 53.
- R4: A rising edge on pps_i that is present before clock edge k takes effect at clock edge k+2 (two synchronizer flops, then the edge detector). On that edge the fraction and sub-fraction become 0. If the fraction just before that edge had bit 31 set, seconds increase by one.
- R5: In the realignment of R4, if the fraction had bit 31 clear, the wrap has already happened and the seconds value is left unchanged.
- R6: Holding pps_i high realigns only once. The fraction then keeps advancing for as long as the level stays high.
- R7: pps_period_o is the number of clocks between the last two recognized pulse edges. pps_period_valid_o rises on the second recognized edge after reset and stays high.
- R8: pps_lost_o goes high LOSS_CYCLES = CLK_HZ + CLK_HZ/2 clocks after the last recognized edge if no new edge arrives. It returns to 0 on the next recognized edge. Time keeps advancing either way.
- R9: If the interval between two edges exceeds LOSS_CYCLES, pps_period_o reports LOSS_CYCLES.
- R10: Every rx beat appears on tx one clock later with the same data and with tx_last_o = 0.
- R11: The clock after a frame's last beat is forwarded, one extra beat is emitted with tx_last_o = 1. Its low 64 bits hold the time_o value that was present while the frame's first beat was presented. Seconds are in bits 63:32 and the fraction in bits 31:0.
- R12: A frame of a single beat (rx_valid_i and rx_last_i together, with no frame in progress) is stamped and closed the same way. Each last beat must be followed by at least one idle cycle on rx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timestamp clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pps_i | input | 1 | Asynchronous pulse-per-second |
| incr_i | input | 64 | Per-cycle increment, 32.32 in units of 2^-32 s |
| time_o | output | 64 | Current time {seconds, fraction} |
| pps_period_o | output | CNT_W | Clocks between the last two pulse edges |
| pps_period_valid_o | output | 1 | pps_period_o holds a measured interval |
| pps_lost_o | output | 1 | Pulse missing too long |
| rx_valid_i | input | 1 | Receive beat valid |
| rx_last_i | input | 1 | Receive beat ends frame |
| rx_data_i | input | DATA_W | Receive beat data |
| tx_valid_o | output | 1 | Output beat valid |
| tx_last_o | output | 1 | Output beat ends frame (the stamp beat) |
| tx_data_o | output | DATA_W | Output beat data or stamp |

## Verification
The time value registered at clock edge n is visible from that edge onward. The bench therefore samples every output at the falling edge and compares it with its model after each rising edge. A pulse level driven before edge k is modelled through the same two-flop delay, so realignment and period updates are expected at edge k+2. The loss flag is expected LOSS_CYCLES edges after the realigning edge and is probed five cycles either side of that point. Forwarded beats are expected one edge after they are presented and stamp beats one edge after that. The stamp is the time that was visible while the first beat was on the inputs.

// File: rtl/gps_ts_pkg.sv
package gps_ts_pkg;
    localparam int SEC_W  = 32;
    localparam int FRAC_W = 32;
    localparam int SUB_W  = 32;
    localparam int TIME_W = SEC_W + FRAC_W;
    localparam int INCR_W = FRAC_W + SUB_W;

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [FRAC_W-1:0] frac;
        logic [SUB_W-1:0]  sub;
    } tod_t;
endpackage

// File: rtl/pps_monitor.sv
module pps_monitor #(
    parameter int LOSS_CYCLES = 240_000_000,
    parameter int CNT_W       = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pps_i,
    output logic             pps_edge_o,
    output logic [CNT_W-1:0] period_o,
    output logic             period_valid_o,
    output logic             lost_o
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LOSS_CYCLES);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    typedef struct packed {
        logic [2:0]       sync;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] period;
        logic             seen;
        logic             pvalid;
        logic             lost;
    } mon_t;

    mon_t mon_d, mon_q;
    logic edge_w;

    always_comb begin
        mon_d      = mon_q;
        mon_d.sync = {mon_q.sync[1:0], pps_i};
        edge_w     = mon_q.sync[1] & ~mon_q.sync[2];
        if (edge_w) begin
            mon_d.cnt  = ONE;
            mon_d.seen = 1'b1;
            mon_d.lost = 1'b0;
            if (mon_q.seen) begin
                mon_d.period = mon_q.cnt;
                mon_d.pvalid = 1'b1;
            end
        end else begin
            if (mon_q.cnt < LIMIT) begin
                mon_d.cnt = mon_q.cnt + ONE;
            end
            if (mon_q.cnt >= LIMIT) begin
                mon_d.lost = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mon_q <= '0;
        end else begin
            mon_q <= mon_d;
        end
    end

    assign pps_edge_o     = edge_w;
    assign period_o       = mon_q.period;
    assign period_valid_o = mon_q.pvalid;
    assign lost_o         = mon_q.lost;

    // R8: a recognized edge always clears the loss flag
    p_lost_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pps_edge_o |=> !lost_o);

    // R9: the reported interval never exceeds the loss limit
    p_period_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        period_valid_o |-> (period_o <= LIMIT));

    // R7: the valid flag only rises on an edge
    p_pvalid_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !period_valid_o && !pps_edge_o |=> !period_valid_o);
endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import gps_ts_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INCR_W-1:0] incr_i,
    input  logic              realign_i,
    output logic [TIME_W-1:0] time_o
);
    tod_t tod_d, tod_q;
    logic [SUB_W:0]  sub_sum;
    logic [FRAC_W:0] frac_sum;

    always_comb begin
        tod_d    = tod_q;
        sub_sum  = {1'b0, tod_q.sub} + {1'b0, incr_i[SUB_W-1:0]};
        frac_sum = {1'b0, tod_q.frac} + {1'b0, incr_i[INCR_W-1:SUB_W]}
                 + {{FRAC_W{1'b0}}, sub_sum[SUB_W]};
        if (realign_i) begin
            tod_d.sub  = '0;
            tod_d.frac = '0;
            tod_d.sec  = tod_q.sec + {{(SEC_W-1){1'b0}}, tod_q.frac[FRAC_W-1]};
        end else begin
            tod_d.sub  = sub_sum[SUB_W-1:0];
            tod_d.frac = frac_sum[FRAC_W-1:0];
            tod_d.sec  = tod_q.sec + {{(SEC_W-1){1'b0}}, frac_sum[FRAC_W]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tod_q <= '0;
        end else begin
            tod_q <= tod_d;
        end
    end

    assign time_o = {tod_q.sec, tod_q.frac};

    // R2: seconds move by at most one per clock between realignments
    p_sec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !realign_i |=> (time_o[TIME_W-1:FRAC_W] == $past(time_o[TIME_W-1:FRAC_W])) ||
                       (time_o[TIME_W-1:FRAC_W] == $past(time_o[TIME_W-1:FRAC_W]) + 1'b1));

    // R4: realignment leaves a zero fraction
    p_realign_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        realign_i |=> (time_o[FRAC_W-1:0] == '0));

    // R5: realignment in the early half keeps the seconds
    p_early_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        realign_i && !time_o[FRAC_W-1] |=> $stable(time_o[TIME_W-1:FRAC_W]));
endmodule

// File: rtl/frame_stamper.sv
module frame_stamper
    import gps_ts_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] time_i,
    input  logic              rx_valid_i,
    input  logic              rx_last_i,
    input  logic [DATA_W-1:0] rx_data_i,
    output logic              tx_valid_o,
    output logic              tx_last_o,
    output logic [DATA_W-1:0] tx_data_o
);
    typedef struct packed {
        logic              in_frame;
        logic              pend;
        logic [TIME_W-1:0] stamp;
        logic              ovalid;
        logic              olast;
        logic [DATA_W-1:0] odata;
    } stp_t;

    stp_t stp_d, stp_q;
    logic first_w;

    always_comb begin
        stp_d   = stp_q;
        first_w = rx_valid_i & ~stp_q.in_frame;
        if (first_w) begin
            stp_d.stamp = time_i;
        end
        if (rx_valid_i) begin
            stp_d.in_frame = ~rx_last_i;
        end
        stp_d.pend = rx_valid_i & rx_last_i;
        if (rx_valid_i) begin
            stp_d.ovalid = 1'b1;
            stp_d.olast  = 1'b0;
            stp_d.odata  = rx_data_i;
        end else if (stp_q.pend) begin
            stp_d.ovalid = 1'b1;
            stp_d.olast  = 1'b1;
            stp_d.odata  = DATA_W'(stp_q.stamp);
        end else begin
            stp_d.ovalid = 1'b0;
            stp_d.olast  = 1'b0;
            stp_d.odata  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stp_q <= '0;
        end else begin
            stp_q <= stp_d;
        end
    end

    assign tx_valid_o = stp_q.ovalid;
    assign tx_last_o  = stp_q.olast;
    assign tx_data_o  = stp_q.odata;

    // R12: the receive side leaves an idle cycle after each last beat
    p_idle_after_last_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_i && rx_last_i |=> !rx_valid_i);

    // R11: a closing beat only follows a last beat two edges earlier
    p_stamp_after_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && tx_last_o |-> $past(rx_valid_i && rx_last_i, 2));

    // R10: a presented beat is always forwarded as a non-final beat
    p_forward_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_i |=> tx_valid_o && !tx_last_o);
endmodule

// File: rtl/gps_stamper.sv
module gps_stamper
    import gps_ts_pkg::*;
#(
    parameter int CLK_HZ = 160_000_000,
    parameter int DATA_W = 64,
    parameter int CNT_W  = $clog2(CLK_HZ + CLK_HZ / 2 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pps_i,
    input  logic [63:0]       incr_i,
    output logic [63:0]       time_o,
    output logic [CNT_W-1:0]  pps_period_o,
    output logic              pps_period_valid_o,
    output logic              pps_lost_o,
    input  logic              rx_valid_i,
    input  logic              rx_last_i,
    input  logic [DATA_W-1:0] rx_data_i,
    output logic              tx_valid_o,
    output logic              tx_last_o,
    output logic [DATA_W-1:0] tx_data_o
);
    localparam int LOSS_CYCLES = CLK_HZ + CLK_HZ / 2;

    logic              pps_edge;
    logic [TIME_W-1:0] now;

    pps_monitor #(
        .LOSS_CYCLES(LOSS_CYCLES),
        .CNT_W      (CNT_W)
    ) u_mon (
        .clk           (clk),
        .rst_n         (rst_n),
        .pps_i         (pps_i),
        .pps_edge_o    (pps_edge),
        .period_o      (pps_period_o),
        .period_valid_o(pps_period_valid_o),
        .lost_o        (pps_lost_o)
    );

    tod_counter u_tod (
        .clk      (clk),
        .rst_n    (rst_n),
        .incr_i   (incr_i),
        .realign_i(pps_edge),
        .time_o   (now)
    );

    frame_stamper #(
        .DATA_W(DATA_W)
    ) u_stp (
        .clk       (clk),
        .rst_n     (rst_n),
        .time_i    (now),
        .rx_valid_i(rx_valid_i),
        .rx_last_i (rx_last_i),
        .rx_data_i (rx_data_i),
        .tx_valid_o(tx_valid_o),
        .tx_last_o (tx_last_o),
        .tx_data_o (tx_data_o)
    );

    assign time_o = now;
endmodule

// File: tb/sim_gps_stamper.sv
module sim_gps_stamper;
    localparam int CLK_PERIOD = 10;
    localparam int HZ         = 64;
    localparam int LOSS       = HZ + HZ / 2;
    localparam int CW         = $clog2(HZ + HZ / 2 + 1);
    localparam logic [63:0] NOM = {32'h0400_0000, 32'h0};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pps = 1'b0;
    logic [63:0]   incr = '0;
    logic [63:0]   time_w;
    logic [CW-1:0] period_w;
    logic          pvalid_w, lost_w;
    logic          rxv = 1'b0, rxl = 1'b0;
    logic [63:0]   rxd = '0;
    logic          txv, txl;
    logic [63:0]   txd;

    int checks = 0, fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    // model state
    logic [31:0] m_sec = '0, m_frac = '0, m_sub = '0;
    logic [2:0]  sh = '0;
    bit          b_inframe = 1'b0, b_pend = 1'b0;
    logic [63:0] b_stamp = '0;
    bit          e_valid = 1'b0, e_last = 1'b0;
    logic [63:0] e_data = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gps_stamper #(.CLK_HZ(HZ), .DATA_W(64)) u0 (
        .clk(clk), .rst_n(rst_n), .pps_i(pps), .incr_i(incr),
        .time_o(time_w), .pps_period_o(period_w),
        .pps_period_valid_o(pvalid_w), .pps_lost_o(lost_w),
        .rx_valid_i(rxv), .rx_last_i(rxl), .rx_data_i(rxd),
        .tx_valid_o(txv), .tx_last_o(txl), .tx_data_o(txd)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // one rising edge with model update, outputs compared at the falling edge
    task automatic cycle();
        logic [32:0] ss, fs;
        bit pe;
        pe = sh[1] & ~sh[2];
        // expected stream output
        if (rxv && !b_inframe) b_stamp = {m_sec, m_frac};
        if (rxv) begin
            e_valid = 1'b1; e_last = 1'b0; e_data = rxd;
        end else if (b_pend) begin
            e_valid = 1'b1; e_last = 1'b1; e_data = b_stamp;
        end else begin
            e_valid = 1'b0; e_last = 1'b0; e_data = '0;
        end
        if (rxv) b_inframe = !rxl;
        b_pend = rxv && rxl;
        // expected time
        if (pe) begin
            m_sec  = m_sec + {31'd0, m_frac[31]};
            m_frac = '0;
            m_sub  = '0;
        end else begin
            ss = {1'b0, m_sub} + {1'b0, incr[31:0]};
            fs = {1'b0, m_frac} + {1'b0, incr[63:32]} + {32'd0, ss[32]};
            m_sub  = ss[31:0];
            m_frac = fs[31:0];
            m_sec  = m_sec + {31'd0, fs[32]};
        end
        sh = {sh[1:0], pps};
        @(posedge clk);
        @(negedge clk);
        cyc++;
        check(time_w == {m_sec, m_frac}, "R2/R3 time", time_w, {m_sec, m_frac});
        check(txv == e_valid, "R10/R11 tx_valid", {63'd0, txv}, {63'd0, e_valid});
        if (e_valid) begin
            check(txl == e_last, e_last ? "R11 tx_last" : "R10 tx_last", {63'd0, txl}, {63'd0, e_last});
            check(txd == e_data, e_last ? "R11 stamp" : "R10 data", txd, e_data);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic pulse();
        pps = 1'b1;
        run(3);
        pps = 1'b0;
        run(HZ - 3);
    endtask

    task automatic send_frame(input int n);
        for (int i = 0; i < n; i++) begin
            rxv = 1'b1; rxl = (i == n - 1); rxd = {$urandom, $urandom};
            cycle();
        end
        rxv = 1'b0; rxl = 1'b0;
        cycle();
    endtask

    initial begin
        for (int i = 0; i < 200_000; i++) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [63:0] t0, fb;
        int rem, gap, pc, per;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state before the first active edge
        check(time_w == 64'd0, "R1 time", time_w, 64'd0);
        check(!lost_w && !pvalid_w && !txv, "R1 flags", {61'd0, lost_w, pvalid_w, txv}, 64'd0);

        // R2: exactly HZ steps of 2^32/HZ wrap into one second
        incr = NOM;
        run(HZ);
        check(time_w == {32'd1, 32'd0}, "R2 wrap", time_w, {32'd1, 32'd0});

        // R3: two half-unit steps carry once
        incr = {32'd26, 32'h8000_0000};
        t0 = time_w;
        run(2);
        check(time_w[31:0] - t0[31:0] == 32'd53, "R3 fraction step", {32'd0, time_w[31:0] - t0[31:0]}, 64'd53);

        // R4: realign in the late half of a second
        incr = NOM;
        while (time_w[31:26] != 6'd48) cycle();
        pps = 1'b1;
        run(2);
        fb = time_w;
        cycle();
        check(time_w == {fb[63:32] + 32'd1, 32'd0}, "R4 late realign", time_w, {fb[63:32] + 32'd1, 32'd0});
        // R6: a held level does not realign again
        run(10);
        check(time_w[31:0] == 32'd10 << 26, "R6 held level", {32'd0, time_w[31:0]}, {32'd0, 32'd10 << 26});
        pps = 1'b0;
        run(4);

        // R5: realign in the early half of a second
        while (time_w[31:26] != 6'd8) cycle();
        pps = 1'b1;
        run(2);
        fb = time_w;
        cycle();
        check(time_w == {fb[63:32], 32'd0}, "R5 early realign", time_w, {fb[63:32], 32'd0});
        pps = 1'b0;
        run(HZ);

        // R7: regular pulses give the interval in clocks
        pulse(); pulse(); pulse();
        check(pvalid_w, "R7 period valid", {63'd0, pvalid_w}, 64'd1);
        check(int'(period_w) == HZ, "R7 period", {57'd0, period_w}, 64'(HZ));

        // R8: loss flag around the limit
        run(LOSS - 5 - (HZ - 3));
        check(!lost_w, "R8 not yet lost", {63'd0, lost_w}, 64'd0);
        run(10);
        check(lost_w, "R8 lost", {63'd0, lost_w}, 64'd1);
        run(50);
        pulse();
        check(!lost_w, "R8 cleared by edge", {63'd0, lost_w}, 64'd0);
        // R9: overlong interval reports the limit
        check(int'(period_w) == LOSS, "R9 saturated period", {57'd0, period_w}, 64'(LOSS));

        // R12 and R11: single-beat and multi-beat frames
        send_frame(1);
        send_frame(1);
        send_frame(4);
        run(3);

        // mixed random traffic, pulse timing and increments
        rem = 0; gap = 0; pc = 0; per = 60;
        for (int i = 0; i < 4000; i++) begin
            if (gap > 0) begin
                rxv = 1'b0; rxl = 1'b0; gap--;
            end else begin
                if (rem == 0) rem = 1 + int'($urandom % 6);
                rxv = 1'b1; rxd = {$urandom, $urandom};
                rxl = (rem == 1);
                rem--;
                if (rem == 0) gap = 1 + int'($urandom % 3);
            end
            pps = (pc < 3);
            pc++;
            if (pc >= per) begin
                pc = 0;
                per = 50 + int'($urandom % 40);
            end
            if ($urandom % 200 == 0)
                incr = {32'h0400_0000 + 32'($urandom % 64) - 32'd32, $urandom};
            cycle();
        end
        rxv = 1'b0; rxl = 1'b0; pps = 1'b0;
        run(4);
        finish_run();
    end
endmodule